// File: doc/BRIEF.md
# Mode-Selectable Synthesizer Divider and Reference

This block is the digital divider section of a frequency synthesizer. A programmable counter divides one of two prescaled RF edge streams (a high-band stream and a low-band stream, each given as a one-cycle tick in the system clock domain). A second counter divides a crystal tick stream down to the comparison frequency. Each counter emits a single-cycle pulse for every completed period, and both pulses go to a phase detector outside the block.

The meaning of the 16-bit divide word depends on two mode bits. The block can use twice the word on the high-band stream, the word itself on the low-band stream, or only the upper twelve bits on the low-band stream. A 4-bit reference code picks the reference ratio. Two reserved codes put the synthesizer into an inhibit state, and one of them also requests that the crystal oscillator stop. A separate force bit drives the charge pump low so that a stalled VCO can be recovered. New ratios are taken only when a counter reaches its terminal count, so a period is never cut short.

Top module: `pll_divider`

## Requirements
- R1: With `hb_mode`=1 the programmable counter counts only `hb_tick` and gives one `vco_pulse` every 2×`div_word` ticks; `lb_tick` has no effect.
- R2: With `hb_mode`=0 and `direct_mode`=1 the programmable counter counts only `lb_tick` and gives one `vco_pulse` every `div_word` ticks; `hb_tick` has no effect.
- R3: With `hb_mode`=0 and `direct_mode`=0 the period is `div_word[15:4]` `lb_tick` ticks, and `div_word[3:0]` has no effect.
- R4: The reference counter divides `xtal_tick` by 3 for codes 0–3, 6 for code 4, 12 for code 5, 24 for codes 6–7, 15 for codes 8–10, 75 for code 11, 25 for code 12 and 5 for code 13.
- R5: Each pulse lasts one cycle and appears in the cycle after the clock edge that takes the tick. The first tick after reset, or after leaving inhibit, produces a pulse.
- R6: A ratio that changes in the middle of a period takes effect only at the next terminal count. The current period completes with the old ratio.
- R7: Code 15 is inhibit. Both counters are cleared and produce no pulses, `counter_halt`=1, `pump_mode`=1 (high impedance), and `osc_stop`=0.
- R8: Code 14 does everything code 15 does and also sets `osc_stop`=1.
- R9: `pump_mode` is 2 (forced low) when `pump_force`=1 outside inhibit. Inhibit takes priority with value 1, and the value is 0 (normal) otherwise. `pump_mode`, `counter_halt` and `osc_stop` follow their inputs with one cycle of latency, and all three are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_tick | input | 1 | High-band prescaled edge strobe |
| lb_tick | input | 1 | Low-band prescaled edge strobe |
| xtal_tick | input | 1 | Crystal edge strobe |
| div_word | input | 16 | Programmable divide word |
| hb_mode | input | 1 | Selects the high band with a doubled ratio |
| direct_mode | input | 1 | In the low band, uses the full word instead of bits 15:4 |
| ref_code | input | 4 | Reference ratio / inhibit code |
| pump_force | input | 1 | Force the charge pump low |
| vco_pulse | output | 1 | Divided RF pulse |
| ref_pulse | output | 1 | Divided reference pulse |
| pump_mode | output | 2 | 0 normal, 1 high impedance, 2 forced low |
| counter_halt | output | 1 | Dividers and frequency counter stopped |
| osc_stop | output | 1 | Crystal oscillator stop request |

## Verification
Every reference code from 0 to 13 is swept over three full periods, with a pulse expected exactly when the tick index is a multiple of the expected ratio. This separates all eight ratios and the code groups that share one. The three divide modes are run with several words each. The doubled mode is told apart from the direct mode by its period. The twelve-bit mode is run with a different junk low nibble for each word, which catches any use of those bits. Ticks on the band that is not selected must leave the output silent. A mid-period ratio change must show the old period completing before the new one starts. The inhibit codes, the force bit and their priority are checked through the pump and halt outputs.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    localparam int DIV_W  = 16;
    localparam int PROG_W = DIV_W + 1;
    localparam int NIB_W  = 4;
    localparam int REF_W  = 7;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_HALT      = 4'd15;
    localparam logic [CODE_W-1:0] CODE_HALT_XOSC = 4'd14;

    typedef enum logic [1:0] {
        PUMP_RUN  = 2'd0,
        PUMP_OPEN = 2'd1,
        PUMP_SINK = 2'd2
    } pump_mode_t;

    typedef struct packed {
        logic              halt;
        logic              osc_off;
        logic              sel_hb;
        logic [PROG_W-1:0] prog_reload;
        logic [REF_W-1:0]  ref_reload;
    } div_cfg_t;

    function automatic logic [REF_W-1:0] ref_ratio(input logic [CODE_W-1:0] code);
        logic [REF_W-1:0] r;
        case (code)
            4'd0, 4'd1, 4'd2, 4'd3: r = REF_W'(3);
            4'd4:                   r = REF_W'(6);
            4'd5:                   r = REF_W'(12);
            4'd6, 4'd7:             r = REF_W'(24);
            4'd8, 4'd9, 4'd10:      r = REF_W'(15);
            4'd11:                  r = REF_W'(75);
            4'd12:                  r = REF_W'(25);
            4'd13:                  r = REF_W'(5);
            default:                r = REF_W'(1);
        endcase
        return r;
    endfunction

    function automatic logic [PROG_W-1:0] prog_ratio(input logic [DIV_W-1:0] word,
                                                     input logic hb, input logic direct);
        logic [PROG_W-1:0] r;
        if (hb)
            r = {word, 1'b0};
        else if (direct)
            r = {1'b0, word};
        else
            r = PROG_W'(word[DIV_W-1:NIB_W]);
        return r;
    endfunction

endpackage

// File: rtl/pll_cfg_decode.sv
module pll_cfg_decode
    import pll_div_pkg::*;
(
    input  logic [DIV_W-1:0]  div_word,
    input  logic              hb_mode,
    input  logic              direct_mode,
    input  logic [CODE_W-1:0] ref_code,
    output div_cfg_t          cfg
);
    logic [PROG_W-1:0] prog_n;
    logic [REF_W-1:0]  ref_n;

    always_comb begin
        prog_n          = prog_ratio(div_word, hb_mode, direct_mode);
        ref_n           = ref_ratio(ref_code);
        cfg.halt        = (ref_code == CODE_HALT) || (ref_code == CODE_HALT_XOSC);
        cfg.osc_off     = (ref_code == CODE_HALT_XOSC);
        cfg.sel_hb      = hb_mode;
        cfg.prog_reload = prog_n - PROG_W'(1);
        cfg.ref_reload  = ref_n - REF_W'(1);
    end
endmodule

// File: rtl/pll_tc_counter.sv
module pll_tc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic         pulse
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt == '0) begin
                    pulse <= 1'b1;
                    cnt   <= reload;
                end else begin
                    cnt <= cnt - W'(1);
                end
            end
        end
    end

    // R5: a pulse only follows an accepted tick
    p_pulse_follows_tick_r5: assert property (@(posedge clk) disable iff (rst)
        pulse |-> ($past(tick) && !$past(hold)));

    // R7: holding clears the count and silences the output
    p_hold_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(hold) && !$past(rst)) |-> (cnt == '0 && !pulse));

    // R6: without a tick the count stays put
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hold) |=> $stable(cnt));
endmodule

// File: rtl/pll_divider.sv
module pll_divider
    import pll_div_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hb_tick,
    input  logic          lb_tick,
    input  logic          xtal_tick,
    input  logic [DW-1:0] div_word,
    input  logic          hb_mode,
    input  logic          direct_mode,
    input  logic [CW-1:0] ref_code,
    input  logic          pump_force,
    output logic          vco_pulse,
    output logic          ref_pulse,
    output logic [1:0]    pump_mode,
    output logic          counter_halt,
    output logic          osc_stop
);
    div_cfg_t   cfg;
    logic       rf_tick;
    pump_mode_t pump_q;

    pll_cfg_decode u_dec (
        .div_word    (div_word),
        .hb_mode     (hb_mode),
        .direct_mode (direct_mode),
        .ref_code    (ref_code),
        .cfg         (cfg)
    );

    assign rf_tick = cfg.sel_hb ? hb_tick : lb_tick;

    pll_tc_counter #(.W(PROG_W)) u_prog (
        .clk    (clk),
        .rst    (rst),
        .hold   (cfg.halt),
        .tick   (rf_tick),
        .reload (cfg.prog_reload),
        .pulse  (vco_pulse)
    );

    pll_tc_counter #(.W(REF_W)) u_ref (
        .clk    (clk),
        .rst    (rst),
        .hold   (cfg.halt),
        .tick   (xtal_tick),
        .reload (cfg.ref_reload),
        .pulse  (ref_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pump_q       <= PUMP_RUN;
            counter_halt <= 1'b0;
            osc_stop     <= 1'b0;
        end else begin
            counter_halt <= cfg.halt;
            osc_stop     <= cfg.osc_off;
            if (cfg.halt)
                pump_q <= PUMP_OPEN;
            else if (pump_force)
                pump_q <= PUMP_SINK;
            else
                pump_q <= PUMP_RUN;
        end
    end

    assign pump_mode = pump_q;

    // R7: halted state always shows an open pump
    p_halt_open_r7: assert property (@(posedge clk) disable iff (rst)
        counter_halt |-> (pump_mode == 2'd1));

    // R8: oscillator stop only within inhibit
    p_osc_in_halt_r8: assert property (@(posedge clk) disable iff (rst)
        osc_stop |-> counter_halt);

    // R7: no pulses while halted
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        counter_halt |-> (!vco_pulse && !ref_pulse));

    // R9: force request outside inhibit yields a sinking pump next cycle
    p_force_sink_r9: assert property (@(posedge clk) disable iff (rst)
        (pump_force && !cfg.halt) |=> (pump_mode == 2'd2));
endmodule

// File: tb/pll_divider_test.sv
module pll_divider_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hb_tick = 1'b0, lb_tick = 1'b0, xtal_tick = 1'b0;
    logic [15:0] div_word = 16'd0;
    logic        hb_mode = 1'b0, direct_mode = 1'b0, pump_force = 1'b0;
    logic [3:0]  ref_code = 4'd0;
    logic        vco_pulse, ref_pulse, counter_halt, osc_stop;
    logic [1:0]  pump_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pll_divider uut (
        .clk(clk), .rst(rst), .hb_tick(hb_tick), .lb_tick(lb_tick),
        .xtal_tick(xtal_tick), .div_word(div_word), .hb_mode(hb_mode),
        .direct_mode(direct_mode), .ref_code(ref_code), .pump_force(pump_force),
        .vco_pulse(vco_pulse), .ref_pulse(ref_pulse), .pump_mode(pump_mode),
        .counter_halt(counter_halt), .osc_stop(osc_stop)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic pulse_src(input int src, input logic v);
        case (src)
            0: hb_tick = v;
            1: lb_tick = v;
            default: xtal_tick = v;
        endcase
    endtask

    // src 0 hb, 1 lb, 2 xtal; expect a pulse when index is a multiple of d
    task automatic run_div(input int src, input int d, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pulse_src(src, 1'b1);
            @(negedge clk); pulse_src(src, 1'b0);
            if (int'(src == 2 ? ref_pulse : vco_pulse) != int'((i % d) == 0)) bad++;
        end
        chk(tag, bad, 0);
    endtask

    task automatic count_pulses(input int src, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pulse_src(src, 1'b1);
            @(negedge clk); pulse_src(src, 1'b0);
            cnt += int'(vco_pulse) + int'(ref_pulse);
        end
    endtask

    function automatic int exp_ref(input int c);
        if (c <= 3) return 3;
        if (c == 4) return 6;
        if (c == 5) return 12;
        if (c <= 7) return 24;
        if (c <= 10) return 15;
        if (c == 11) return 75;
        if (c == 12) return 25;
        return 5;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        do_reset();
        @(negedge clk);
        chk("R9 reset pump_mode", pump_mode, 0);
        chk("R9 reset counter_halt", counter_halt, 0);
        chk("R9 reset osc_stop", osc_stop, 0);
        chk("R5 reset pulses", int'(vco_pulse) + int'(ref_pulse), 0);

        // R4: every valid reference code
        for (int c = 0; c < 14; c++) begin
            ref_code = 4'(c);
            do_reset();
            run_div(2, exp_ref(c), 3 * exp_ref(c), $sformatf("R4 code %0d", c));
        end
        ref_code = 4'd0;

        // R1: doubled high-band ratio
        hb_mode = 1'b1;
        for (int k = 0; k < 3; k++) begin
            div_word = 16'(272 + 13 * k);
            do_reset();
            run_div(0, 2 * (272 + 13 * k), 2 * 2 * (272 + 13 * k) + 1,
                    $sformatf("R1 N=%0d", 272 + 13 * k));
        end
        do_reset();
        count_pulses(1, 20, cnt);
        chk("R1 lb ignored", cnt, 0);

        // R2: direct low-band ratio
        hb_mode = 1'b0; direct_mode = 1'b1;
        for (int k = 0; k < 3; k++) begin
            div_word = 16'(272 + 100 * k);
            do_reset();
            run_div(1, 272 + 100 * k, 2 * (272 + 100 * k) + 1,
                    $sformatf("R2 N=%0d", 272 + 100 * k));
        end
        do_reset();
        count_pulses(0, 20, cnt);
        chk("R2 hb ignored", cnt, 0);

        // R3: twelve-bit mode, junk low nibble
        direct_mode = 1'b0;
        for (int n = 4; n <= 12; n++) begin
            div_word = {12'(n), 4'(n ^ 5)};
            do_reset();
            run_div(1, n, 2 * n + 1, $sformatf("R3 N=%0d", n));
        end

        // R6: ratio change mid-period
        direct_mode = 1'b1; div_word = 16'd5;
        do_reset();
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin
                if (i == 2) div_word = 16'd9;
                @(negedge clk); lb_tick = 1'b1;
                @(negedge clk); lb_tick = 1'b0;
                if (int'(vco_pulse) != int'(i == 0 || i == 5 || i == 14)) bad++;
            end
            chk("R6 change at terminal", bad, 0);
        end

        // R7: inhibit code 15
        div_word = 16'd3; ref_code = 4'd15;
        do_reset();
        @(negedge clk);
        begin
            int c2;
            count_pulses(0, 8, cnt);
            count_pulses(1, 8, c2);
            cnt += c2;
            count_pulses(2, 8, c2);
            cnt += c2;
        end
        chk("R7 no pulses", cnt, 0);
        chk("R7 counter_halt", counter_halt, 1);
        chk("R7 pump open", pump_mode, 1);
        chk("R7 osc running", osc_stop, 0);

        // R8: code 14
        ref_code = 4'd14;
        @(negedge clk);
        count_pulses(1, 8, cnt);
        chk("R8 no pulses", cnt, 0);
        chk("R8 osc_stop", osc_stop, 1);
        chk("R8 counter_halt", counter_halt, 1);
        chk("R8 pump open", pump_mode, 1);

        // R5: leaving inhibit, first tick pulses
        ref_code = 4'd13;
        @(negedge clk);
        chk("R5 halt released", counter_halt, 0);
        run_div(1, 3, 7, "R5 first tick after inhibit lb");
        run_div(2, 5, 11, "R5 first tick after inhibit xtal");

        // R9: force and priority
        pump_force = 1'b1;
        @(negedge clk);
        chk("R9 forced low", pump_mode, 2);
        ref_code = 4'd15;
        @(negedge clk);
        chk("R9 inhibit over force", pump_mode, 1);
        ref_code = 4'd0; pump_force = 1'b0;
        @(negedge clk);
        chk("R9 normal", pump_mode, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule